// File: doc/BRIEF.md
# Control Store Debug Access Sequencer

This block paces a debug host's access to a wide microcode control-store word, one byte-sized slot per command. The host raises a read or write command and holds it. The sequencer then walks a fixed six-state path. On that path it pauses the microcode engine, opens the control-store address for reading, and issues control-store read and write enables. For the slots that belong to a temporary register rather than to the control store, it issues temp-register read and write strobes instead. When the host drops the command, the sequencer advances its slot pointer so that the next command reaches the next slot. After the last control-store slot, the pointer wraps to slot 0 and pulses an address-increment line, which moves an external address counter on to the next word.

The RAM, the address counter and the temp register lie outside the block and see only its strobes. The current slot is held in an internal register. While the sequencer is idle and no command is present, the host can load that register directly.

The states are IDLE (0), FETCH (1), COMMIT (2), SETTLE (3), DRAIN (4) and HOLD (5). The transitions are as follows:
- IDLE goes to FETCH when a command is present and otherwise stays in IDLE.
- FETCH goes to COMMIT, COMMIT goes to SETTLE, SETTLE goes to DRAIN and DRAIN goes to HOLD, each unconditionally after one cycle.
- HOLD stays in HOLD while a command is present and goes back to IDLE on release.
- Any unused state code goes to IDLE.

All strobe outputs are Mealy functions of the state, the command lines and the current slot.

Top module: `csdbg_seq`

## Requirements
- R1: A synchronous reset puts the sequencer in IDLE with slot 0. While reset is held, run_o is 1, inc_addr_n, rd_addr_n and tmp_rd_n are 1, and tmp_wr, cs_rd_en and cs_wr_en are 0.
- R2: In IDLE with no command, all outputs are in their inactive state and run_o is 1. In IDLE with rd_cmd or wr_cmd high and slot at most 7, run_o is 0 and rd_addr_n is 0 in that same cycle.
- R3: cs_rd_en is 1 only in FETCH and COMMIT, and only when (wr_cmd and slot is 2..7) or (rd_cmd and slot is at most 9).
- R4: tmp_rd_n (active low) is 0 in the following cases: in FETCH or COMMIT on a read with slot at least 10; in SETTLE or DRAIN on any read; in HOLD while rd_cmd is held.
- R5: tmp_wr is 1 exactly in COMMIT when the cycle is not a read with slot at least 10.
- R6: cs_wr_en is 1 exactly in COMMIT when wr_cmd is high and the slot is at most 7.
- R7: For slot at most 7, run_o is 0 in FETCH, COMMIT, SETTLE and DRAIN. For slot at most 7, rd_addr_n is 0 in FETCH and COMMIT. For slots 8 to 15, run_o stays 1 and rd_addr_n stays 1.
- R8: After a command starts in IDLE, the states FETCH, COMMIT, SETTLE and DRAIN each last exactly one cycle whatever the command lines do. HOLD then lasts while a command is held, so cs_wr_en for a write appears exactly two cycles after the starting cycle.
- R9: The cycle in HOLD with no command updates the slot as follows:
  - Slot 7 becomes 0, and inc_addr_n is 0 for that one cycle.
  - Any other slot below 10 increments by one.
  - Slots 10 to 15 keep their value.
- R10: slot_ld loads slot_ld_val into the slot on the next edge only in IDLE with no command. In any other cycle it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_cmd | input | 1 | Host read command, held for the access |
| wr_cmd | input | 1 | Host write command, held for the access |
| slot_ld | input | 1 | Load the slot register (honoured only in IDLE with no command) |
| slot_ld_val | input | 4 | Value loaded into the slot register |
| slot_o | output | 4 | Current slot index |
| run_o | output | 1 | Engine run enable; 0 halts the engine |
| inc_addr_n | output | 1 | Control-store address increment, active low |
| rd_addr_n | output | 1 | Control-store read-address enable, active low |
| tmp_rd_n | output | 1 | Temp-register read strobe, active low |
| tmp_wr | output | 1 | Temp-register write strobe |
| cs_rd_en | output | 1 | Control-store read enable |
| cs_wr_en | output | 1 | Control-store write enable |

## Verification
The assertions check several properties on every cycle:
- the state-to-state step through the fixed part of the walk;
- that cs_rd_en stays inside FETCH and COMMIT;
- that cs_wr_en needs a write to a control-store slot;
- that the temp read and write strobes never overlap;
- that a halt happens only on slots 0..7;
- that the slot changes only in IDLE or HOLD;
- that an increment pulse is always followed by slot 0.

Some behaviour needs the bench's scenarios instead: the exact strobe pattern for each slot and command mix, the increment sequence 9 to 10, slot 15 holding, and a load that is ignored during a walk. The bench compares every output, cycle by cycle, with a reference model. It drives random commands of random length, some released before HOLD is reached, together with directed wrap and load cases.

// File: rtl/csdbg_pkg.sv
package csdbg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_COMMIT = 3'd2,
        ST_SETTLE = 3'd3,
        ST_DRAIN  = 3'd4,
        ST_HOLD   = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic run;
        logic inc_n;
        logic rdaddr_n;
        logic tmprd_n;
        logic tmpwr;
        logic csrd;
        logic cswr;
    } seq_out_t;

    localparam seq_out_t OUT_QUIET = '{
        run: 1'b1, inc_n: 1'b1, rdaddr_n: 1'b1, tmprd_n: 1'b1,
        tmpwr: 1'b0, csrd: 1'b0, cswr: 1'b0
    };

endpackage

// File: rtl/csdbg_slot_class.sv
module csdbg_slot_class #(
    parameter int SLOT_W    = 4,
    parameter int CS_LAST   = 7,
    parameter int RD_LAST   = 9,
    parameter int WR_FIRST  = 2,
    parameter int TMP_FIRST = 10
) (
    input  logic [SLOT_W-1:0] slot,
    output logic              in_cs,
    output logic              rd_cs_ok,
    output logic              wr_cs_ok,
    output logic              in_tmp,
    output logic              at_wrap
);
    localparam logic [SLOT_W-1:0] CS_LAST_V   = SLOT_W'(CS_LAST);
    localparam logic [SLOT_W-1:0] RD_LAST_V   = SLOT_W'(RD_LAST);
    localparam logic [SLOT_W-1:0] WR_FIRST_V  = SLOT_W'(WR_FIRST);
    localparam logic [SLOT_W-1:0] TMP_FIRST_V = SLOT_W'(TMP_FIRST);

    always_comb begin
        in_cs    = (slot <= CS_LAST_V);
        rd_cs_ok = (slot <= RD_LAST_V);
        wr_cs_ok = (slot >= WR_FIRST_V) && (slot <= CS_LAST_V);
        in_tmp   = (slot >= TMP_FIRST_V);
        at_wrap  = (slot == CS_LAST_V);
    end
endmodule

// File: rtl/csdbg_slot_reg.sv
module csdbg_slot_reg #(
    parameter int SLOT_W    = 4,
    parameter int TMP_FIRST = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              at_wrap,
    input  logic              load_en,
    input  logic [SLOT_W-1:0] load_val,
    output logic [SLOT_W-1:0] slot_q
);
    localparam logic [SLOT_W-1:0] TMP_FIRST_V = SLOT_W'(TMP_FIRST);

    logic [SLOT_W-1:0] slot_d;

    always_comb begin
        slot_d = slot_q;
        if (advance) begin
            if (at_wrap)
                slot_d = '0;
            else if (slot_q < TMP_FIRST_V)
                slot_d = slot_q + 1'b1;
        end else if (load_en) begin
            slot_d = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end
endmodule

// File: rtl/csdbg_out_dec.sv
module csdbg_out_dec
    import csdbg_pkg::*;
(
    input  seq_state_e state,
    input  logic       rd,
    input  logic       wr,
    input  logic       in_cs,
    input  logic       rd_cs_ok,
    input  logic       wr_cs_ok,
    input  logic       in_tmp,
    input  logic       at_wrap,
    output seq_out_t   outs
);
    logic cmd;
    logic cs_read_hit;
    logic tmp_read_hit;

    always_comb begin
        cmd          = rd | wr;
        cs_read_hit  = (wr && wr_cs_ok) || (rd && rd_cs_ok);
        tmp_read_hit = rd && in_tmp;
        outs         = OUT_QUIET;
        unique case (state)
            ST_IDLE: begin
                if (cmd && in_cs) begin
                    outs.run      = 1'b0;
                    outs.rdaddr_n = 1'b0;
                end
            end
            ST_FETCH: begin
                outs.csrd = cs_read_hit;
                if (in_cs) begin
                    outs.run      = 1'b0;
                    outs.rdaddr_n = 1'b0;
                end
                if (tmp_read_hit) outs.tmprd_n = 1'b0;
            end
            ST_COMMIT: begin
                outs.csrd = cs_read_hit;
                if (in_cs) begin
                    outs.run      = 1'b0;
                    outs.rdaddr_n = 1'b0;
                    outs.cswr     = wr;
                end
                if (tmp_read_hit) outs.tmprd_n = 1'b0;
                else              outs.tmpwr   = 1'b1;
            end
            ST_SETTLE, ST_DRAIN: begin
                if (in_cs) outs.run     = 1'b0;
                if (rd)    outs.tmprd_n = 1'b0;
            end
            ST_HOLD: begin
                if (cmd) begin
                    if (rd) outs.tmprd_n = 1'b0;
                end else if (at_wrap) begin
                    outs.inc_n = 1'b0;
                end
            end
            default: outs = OUT_QUIET;
        endcase
    end
endmodule

// File: rtl/csdbg_seq.sv
module csdbg_seq
    import csdbg_pkg::*;
#(
    parameter int SLOT_W    = 4,
    parameter int CS_LAST   = 7,
    parameter int RD_LAST   = 9,
    parameter int WR_FIRST  = 2,
    parameter int TMP_FIRST = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_cmd,
    input  logic              wr_cmd,
    input  logic              slot_ld,
    input  logic [SLOT_W-1:0] slot_ld_val,
    output logic [SLOT_W-1:0] slot_o,
    output logic              run_o,
    output logic              inc_addr_n,
    output logic              rd_addr_n,
    output logic              tmp_rd_n,
    output logic              tmp_wr,
    output logic              cs_rd_en,
    output logic              cs_wr_en
);
    seq_state_e state_q;
    seq_state_e state_d;
    logic       cmd;
    logic       in_cs, rd_cs_ok, wr_cs_ok, in_tmp, at_wrap;
    logic       advance, load_en;
    seq_out_t   outs;

    assign cmd = rd_cmd | wr_cmd;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd) state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_SETTLE;
            ST_SETTLE: state_d = ST_DRAIN;
            ST_DRAIN:  state_d = ST_HOLD;
            ST_HOLD:   if (!cmd) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign advance = (state_q == ST_HOLD) && !cmd;
    assign load_en = (state_q == ST_IDLE) && !cmd && slot_ld;

    csdbg_slot_class #(
        .SLOT_W(SLOT_W), .CS_LAST(CS_LAST), .RD_LAST(RD_LAST),
        .WR_FIRST(WR_FIRST), .TMP_FIRST(TMP_FIRST)
    ) u_class (
        .slot(slot_o), .in_cs(in_cs), .rd_cs_ok(rd_cs_ok),
        .wr_cs_ok(wr_cs_ok), .in_tmp(in_tmp), .at_wrap(at_wrap)
    );

    csdbg_slot_reg #(.SLOT_W(SLOT_W), .TMP_FIRST(TMP_FIRST)) u_slot (
        .clk(clk), .rst(rst), .advance(advance), .at_wrap(at_wrap),
        .load_en(load_en), .load_val(slot_ld_val), .slot_q(slot_o)
    );

    csdbg_out_dec u_dec (
        .state(state_q), .rd(rd_cmd), .wr(wr_cmd), .in_cs(in_cs),
        .rd_cs_ok(rd_cs_ok), .wr_cs_ok(wr_cs_ok), .in_tmp(in_tmp),
        .at_wrap(at_wrap), .outs(outs)
    );

    assign run_o      = outs.run;
    assign inc_addr_n = outs.inc_n;
    assign rd_addr_n  = outs.rdaddr_n;
    assign tmp_rd_n   = outs.tmprd_n;
    assign tmp_wr     = outs.tmpwr;
    assign cs_rd_en   = outs.csrd;
    assign cs_wr_en   = outs.cswr;
endmodule

// File: rtl/csdbg_seq_chk.sv
module csdbg_seq_chk #(
    parameter int SLOT_W  = 4,
    parameter int CS_LAST = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_cmd,
    input logic              wr_cmd,
    input logic              slot_ld,
    input logic [SLOT_W-1:0] slot_ld_val,
    input logic [SLOT_W-1:0] slot_o,
    input logic              run_o,
    input logic              inc_addr_n,
    input logic              tmp_rd_n,
    input logic              tmp_wr,
    input logic              cs_rd_en,
    input logic              cs_wr_en,
    input logic [2:0]        state_q
);
    localparam logic [SLOT_W-1:0] CS_LAST_V = SLOT_W'(CS_LAST);

    // R1
    a_r1_slot_cleared: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> slot_o == '0);
    // R3
    a_r3_csrd_window: assert property (@(posedge clk) disable iff (rst)
        cs_rd_en |-> (state_q == 3'd1 || state_q == 3'd2));
    // R4
    a_r4_tmprd_needs_read: assert property (@(posedge clk) disable iff (rst)
        !tmp_rd_n |-> rd_cmd);
    // R5
    a_r5_tmp_exclusive: assert property (@(posedge clk) disable iff (rst)
        tmp_wr |-> tmp_rd_n);
    // R6
    a_r6_cswr_cond: assert property (@(posedge clk) disable iff (rst)
        cs_wr_en |-> (wr_cmd && slot_o <= CS_LAST_V && state_q == 3'd2));
    // R7
    a_r7_halt_cs_only: assert property (@(posedge clk) disable iff (rst)
        !run_o |-> slot_o <= CS_LAST_V);
    // R8
    a_r8_fixed_walk: assert property (@(posedge clk) disable iff (rst)
        (state_q != 3'd0 && state_q != 3'd5) |=> state_q == $past(state_q) + 3'd1);
    // R9
    a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        !inc_addr_n |=> slot_o == '0);
    // R9
    a_r9_slot_moves_idle_or_hold: assert property (@(posedge clk) disable iff (rst)
        (slot_o != $past(slot_o)) |-> ($past(state_q) == 3'd0 || $past(state_q) == 3'd5));
    // R10
    a_r10_load_in_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == 3'd0 && !rd_cmd && !wr_cmd && slot_ld) |=> slot_o == $past(slot_ld_val));
endmodule

bind csdbg_seq csdbg_seq_chk #(.SLOT_W(SLOT_W), .CS_LAST(CS_LAST)) u_chk (
    .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .slot_ld(slot_ld), .slot_ld_val(slot_ld_val), .slot_o(slot_o),
    .run_o(run_o), .inc_addr_n(inc_addr_n), .tmp_rd_n(tmp_rd_n),
    .tmp_wr(tmp_wr), .cs_rd_en(cs_rd_en), .cs_wr_en(cs_wr_en),
    .state_q(state_q)
);

// File: tb/csdbg_seq_test.sv
module csdbg_seq_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       rd_cmd, wr_cmd, slot_ld;
    logic [3:0] slot_ld_val;
    logic [3:0] slot_o;
    logic       run_o, inc_addr_n, rd_addr_n, tmp_rd_n, tmp_wr, cs_rd_en, cs_wr_en;

    int checks = 0;
    int fails  = 0;
    int m_state;
    int m_slot;

    always #5 clk = ~clk;

    csdbg_seq uut (
        .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
        .slot_ld(slot_ld), .slot_ld_val(slot_ld_val), .slot_o(slot_o),
        .run_o(run_o), .inc_addr_n(inc_addr_n), .rd_addr_n(rd_addr_n),
        .tmp_rd_n(tmp_rd_n), .tmp_wr(tmp_wr), .cs_rd_en(cs_rd_en),
        .cs_wr_en(cs_wr_en)
    );

    // expected {run, inc_n, rdaddr_n, tmprd_n, tmpwr, csrd, cswr}
    function automatic logic [6:0] f_out(int st, int sl, logic r, logic w);
        logic run = 1, inc_n = 1, ra_n = 1, tr_n = 1, tw = 0, cr = 0, cw = 0;
        logic cmd = r | w;
        if (st == 0) begin
            if (cmd && sl <= 7) begin run = 0; ra_n = 0; end
        end else if (st == 1 || st == 2) begin
            cr = (w && sl >= 2 && sl <= 7) || (r && sl <= 9);
            if (sl <= 7) begin run = 0; ra_n = 0; if (st == 2) cw = w; end
            if (r && sl >= 10) tr_n = 0;
            else if (st == 2) tw = 1;
        end else if (st == 3 || st == 4) begin
            if (sl <= 7) run = 0;
            if (r) tr_n = 0;
        end else if (st == 5) begin
            if (cmd) begin if (r) tr_n = 0; end
            else if (sl == 7) inc_n = 0;
        end
        return {run, inc_n, ra_n, tr_n, tw, cr, cw};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_state <= 0;
            m_slot  <= 0;
        end else begin
            case (m_state)
                0: begin
                    if (rd_cmd | wr_cmd) m_state <= 1;
                    else if (slot_ld) m_slot <= int'(slot_ld_val);
                end
                1, 2, 3, 4: m_state <= m_state + 1;
                5: if (!(rd_cmd | wr_cmd)) begin
                    m_state <= 0;
                    if (m_slot == 7) m_slot <= 0;
                    else if (m_slot < 10) m_slot <= m_slot + 1;
                end
                default: m_state <= 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [6:0] e = f_out(m_state, m_slot, rd_cmd, wr_cmd);
        chk(int'(slot_o) == m_slot, "R9", "slot_o", int'(slot_o), m_slot);
        chk(run_o == e[6], "R7", "run_o", run_o, e[6]);
        chk(inc_addr_n == e[5], "R9", "inc_addr_n", inc_addr_n, e[5]);
        chk(rd_addr_n == e[4], "R7", "rd_addr_n", rd_addr_n, e[4]);
        chk(tmp_rd_n == e[3], "R4", "tmp_rd_n", tmp_rd_n, e[3]);
        chk(tmp_wr == e[2], "R5", "tmp_wr", tmp_wr, e[2]);
        chk(cs_rd_en == e[1], "R3", "cs_rd_en", cs_rd_en, e[1]);
        chk(cs_wr_en == e[0], "R6", "cs_wr_en", cs_wr_en, e[0]);
    endtask

    task automatic cyc(input logic r, input logic w, input logic ld, input logic [3:0] v);
        @(negedge clk);
        rd_cmd = r; wr_cmd = w; slot_ld = ld; slot_ld_val = v;
        #1;
        compare_all();
    endtask

    task automatic load_slot(input logic [3:0] v);
        cyc(0, 0, 1, v);
        cyc(0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        process::self().srandom(32'd2024);
        rst = 1; rd_cmd = 0; wr_cmd = 0; slot_ld = 0; slot_ld_val = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R1 reset state
        chk(slot_o == 0 && run_o && inc_addr_n && rd_addr_n && tmp_rd_n &&
            !tmp_wr && !cs_rd_en && !cs_wr_en, "R1", "reset outputs",
            {slot_o, run_o, inc_addr_n, rd_addr_n, tmp_rd_n, tmp_wr, cs_rd_en, cs_wr_en},
            {4'd0, 7'b1111000});
        rst = 0;

        // R2 idle, no command
        cyc(0, 0, 0, 0);
        chk(run_o == 1 && rd_addr_n == 1, "R2", "idle quiet", {run_o, rd_addr_n}, 3);
        // R2 start of write on slot 0
        cyc(0, 1, 0, 0);
        chk(run_o == 0 && rd_addr_n == 0, "R2", "halt on start", {run_o, rd_addr_n}, 0);
        cyc(0, 1, 0, 0);
        chk(cs_wr_en == 0, "R8", "no cs write in FETCH", cs_wr_en, 0);
        cyc(0, 1, 0, 0);
        chk(cs_wr_en == 1, "R8", "cs write two cycles after start", cs_wr_en, 1);
        cyc(0, 1, 0, 0);
        cyc(0, 1, 0, 0);
        repeat (3) begin
            cyc(0, 1, 0, 0);
            chk(run_o == 1 && cs_wr_en == 0, "R8", "HOLD while held", {run_o, cs_wr_en}, 2);
        end
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        chk(slot_o == 1, "R9", "slot 0 to 1", slot_o, 1);

        // R10 load in idle, then ignored during a walk; R9 wrap from 7
        load_slot(4'd7);
        chk(slot_o == 7, "R10", "idle load", slot_o, 7);
        repeat (6) cyc(0, 1, 1, 4'd3);
        cyc(0, 0, 0, 0);
        chk(inc_addr_n == 0, "R9", "increment pulse on wrap", inc_addr_n, 0);
        cyc(0, 0, 0, 0);
        chk(slot_o == 0, "R10", "load ignored during walk, wrapped", slot_o, 0);
        chk(inc_addr_n == 1, "R9", "pulse lasts one cycle", inc_addr_n, 1);

        // R9 slot 9 goes to 10
        load_slot(4'd9);
        repeat (6) cyc(1, 0, 0, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        chk(slot_o == 10, "R9", "slot 9 to 10", slot_o, 10);

        // R4 temp read on slot 15; R9 slot 15 holds
        load_slot(4'd15);
        cyc(1, 0, 0, 0);
        cyc(1, 0, 0, 0);
        chk(tmp_rd_n == 0 && cs_rd_en == 0, "R4", "temp read in FETCH", {tmp_rd_n, cs_rd_en}, 0);
        repeat (5) cyc(1, 0, 0, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        chk(slot_o == 15, "R9", "slot 15 holds", slot_o, 15);

        // random commands of random length, some released before HOLD
        for (int t = 0; t < 400; t++) begin
            int len  = $urandom_range(1, 8);
            int gap  = $urandom_range(0, 3);
            int kind = $urandom_range(0, 9);
            logic r = (kind < 5) || (kind == 9);
            logic w = (kind >= 5);
            if ($urandom_range(0, 3) == 0) load_slot(4'($urandom_range(0, 15)));
            for (int k = 0; k < len; k++) cyc(r, w, 1'($urandom_range(0, 1)), 4'($urandom));
            for (int k = 0; k <= gap; k++) cyc(0, 0, 0, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule